// File: doc/BRIEF.md
# Raster Dual Interval Timer

This block produces two timing events for an interrupt controller, both locked to the video raster. It receives single-cycle strobes from the display timing generator: a frame-start strobe (end of vertical blanking), a horizontal-blank strobe once per line, and a dot tick once per pixel. It drives two single-cycle event pulses. Masking and priority of these events are left to the interrupt controller.

The first timer counts lines. The frame-start strobe clears it and each horizontal-blank strobe advances it. It fires when the count held at a horizontal blank equals a programmed compare value. A compare value beyond the last line of the frame never matches, and the count never wraps back onto it. The second timer is a dot down-counter. It is reloaded at every horizontal blank and fires once when it reaches zero. It can be restricted to fire only on the line that the first timer selects. Software reaches the compare, reload and control registers over a simple register bus.

Top module: `raster_dual_timer`

## Requirements
- R1: After reset, all three registers read zero, timer 1 is disabled, and neither event pulse is asserted.
- R2: Register bus: address 0 is the 10-bit line compare value, address 1 is the 9-bit dot reload value, and address 2 is control. In control, bit 0 enables timer 1 and bit 7 selects line-gated mode. Unused bits read zero. Read data is combinational from `regAddr`, and a write takes effect at the clock edge where `regWr` is high.
- R3: The line count is cleared by `vblankOut` and incremented by one on each `hblankIn`.
- R4: `timer0Pulse` is high for exactly the one cycle after an `hblankIn` cycle whose line count before the increment equals the compare value. With compare 0, it fires on the first horizontal blank of the frame.
- R5: A compare value that is never reached in a frame produces no pulse. Once the count passes its maximum (1023), no further match occurs until the next `vblankOut`, so a value is never matched twice in one frame.
- R6: Each `hblankIn` loads the dot counter from the reload value. Each `dotTick` decrements it, and it holds at zero. When timer 1 is enabled, `timer1Pulse` is high for one cycle after the tick that brings the counter from 1 to 0, so there is one pulse per line.
- R7: With reload value 0 and timer 1 enabled, `timer1Pulse` is high for the cycle after the `hblankIn`.
- R8: With control bit 0 clear, `timer1Pulse` never asserts.
- R9: In line-gated mode (control bit 7 set), timer 1 fires only on the line that begins with the `hblankIn` at which timer 0 matches.
- R10: When `dotTick` and `hblankIn` coincide, the reload wins and the tick is not counted. When `vblankOut` and `hblankIn` coincide, the clear happens first, so that blank compares against count 0 and leaves the count at 1.
- R11: A write to the compare or reload register during a line does not change the dot count already in progress. The new value is used from the next horizontal blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hblankIn | input | 1 | One-cycle strobe per line at horizontal blank |
| vblankOut | input | 1 | One-cycle strobe at frame start |
| dotTick | input | 1 | One-cycle strobe per dot |
| regWr | input | 1 | Register write enable |
| regAddr | input | 2 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data |
| timer0Pulse | output | 1 | Line compare event |
| timer1Pulse | output | 1 | Dot countdown event |

## Verification
Three pairs of inputs can fall in the same cycle. A dot tick can arrive on the cycle of a horizontal blank. A frame-start strobe can coincide with a horizontal blank. A register write can land in the middle of a dot countdown. The bench drives each pair together on purpose. It then judges the outcome from where the pulse falls, measured in dot ticks since the line began. A pulse one tick early means the coincident tick was counted. A missing timer 0 pulse with compare 0 means the clear was applied after the compare. A pulse at the newly written reload value means the write reached the running count.

// File: rtl/raster_timer_pkg.sv
package raster_timer_pkg;

  typedef struct packed {
    logic frameClear;
    logic lineEdge;
    logic dotStep;
  } rtStrobe_t;

  localparam int ADDR_CMP     = 0;
  localparam int ADDR_RLD     = 1;
  localparam int ADDR_CTL     = 2;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MODE_BIT = 7;

endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import raster_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int CMP_W  = 10,
  parameter int RLD_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hblankIn,
  input  logic              vblankOut,
  input  logic              dotTick,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output rtStrobe_t         strobe,
  output logic [CMP_W-1:0]  cmpVal,
  output logic [RLD_W-1:0]  rldVal,
  output logic              t1En,
  output logic              t1Mode
);

  logic [CMP_W-1:0] cmpReg;
  logic [RLD_W-1:0] rldReg;
  logic             enReg;
  logic             modeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg  <= '0;
      rldReg  <= '0;
      enReg   <= 1'b0;
      modeReg <= 1'b0;
    end else if (regWr) begin
      case (int'(regAddr))
        ADDR_CMP: cmpReg <= regWdata[CMP_W-1:0];
        ADDR_RLD: rldReg <= regWdata[RLD_W-1:0];
        ADDR_CTL: begin
          enReg   <= regWdata[CTL_EN_BIT];
          modeReg <= regWdata[CTL_MODE_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (int'(regAddr))
      ADDR_CMP: regRdata = DATA_W'(cmpReg);
      ADDR_RLD: regRdata = DATA_W'(rldReg);
      ADDR_CTL: begin
        regRdata[CTL_EN_BIT]   = enReg;
        regRdata[CTL_MODE_BIT] = modeReg;
      end
      default: regRdata = '0;
    endcase
  end

  // A line edge takes precedence over a dot in the same cycle (R10)
  always_comb begin
    strobe.frameClear = vblankOut;
    strobe.lineEdge   = hblankIn;
    strobe.dotStep    = dotTick & ~hblankIn;
  end

  assign cmpVal = cmpReg;
  assign rldVal = rldReg;
  assign t1En   = enReg;
  assign t1Mode = modeReg;

  // R2: a write to the control address updates the visible enable
  a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && int'(regAddr) == ADDR_CTL) |=> (t1En == $past(regWdata[CTL_EN_BIT])));

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import raster_timer_pkg::*;
#(
  parameter int CMP_W = 10,
  parameter int RLD_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtStrobe_t        strobe,
  input  logic [CMP_W-1:0] cmpVal,
  input  logic [RLD_W-1:0] rldVal,
  input  logic             t1En,
  input  logic             t1Mode,
  output logic             timer0Pulse,
  output logic             timer1Pulse
);

  localparam int LINE_W = CMP_W;

  logic [LINE_W-1:0] lineCnt;
  logic              lineOvf;
  logic [RLD_W-1:0]  dotCnt;
  logic              lineSel;

  logic [LINE_W-1:0] effCnt;
  logic              effOvf;
  logic              matchNow;
  logic              gateNow;

  // Frame clear is applied before a coincident line compare (R10)
  always_comb begin
    effCnt   = strobe.frameClear ? '0 : lineCnt;
    effOvf   = strobe.frameClear ? 1'b0 : lineOvf;
    matchNow = !effOvf && (effCnt == cmpVal);
    gateNow  = t1En && (!t1Mode || matchNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt     <= '0;
      lineOvf     <= 1'b0;
      dotCnt      <= '0;
      lineSel     <= 1'b0;
      timer0Pulse <= 1'b0;
      timer1Pulse <= 1'b0;
    end else if (strobe.lineEdge) begin
      lineCnt     <= effCnt + 1'b1;
      lineOvf     <= effOvf | (&effCnt);
      lineSel     <= matchNow;
      timer0Pulse <= matchNow;
      dotCnt      <= rldVal;
      timer1Pulse <= (rldVal == '0) && gateNow;
    end else begin
      timer0Pulse <= 1'b0;
      if (strobe.frameClear) begin
        lineCnt <= '0;
        lineOvf <= 1'b0;
      end
      if (strobe.dotStep && dotCnt != '0) begin
        dotCnt      <= dotCnt - 1'b1;
        timer1Pulse <= (dotCnt == RLD_W'(1)) && t1En && (!t1Mode || lineSel);
      end else begin
        timer1Pulse <= 1'b0;
      end
    end
  end

  a_r4_t0_follows_line: assert property (@(posedge clk) disable iff (!rstN)
    timer0Pulse |-> $past(strobe.lineEdge));

  a_r8_t1_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    timer1Pulse |-> $past(t1En));

  a_r6_dot_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.lineEdge) |-> (dotCnt <= $past(dotCnt)));

  a_r3_frame_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.frameClear) && !$past(strobe.lineEdge)) |-> (lineCnt == '0));

  a_r6_pulse_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    timer1Pulse |-> (dotCnt == '0));

endmodule

// File: rtl/raster_dual_timer.sv
module raster_dual_timer
  import raster_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int CMP_W  = 10,
  parameter int RLD_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hblankIn,
  input  logic              vblankOut,
  input  logic              dotTick,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              timer0Pulse,
  output logic              timer1Pulse
);

  rtStrobe_t        strobe;
  logic [CMP_W-1:0] cmpVal;
  logic [RLD_W-1:0] rldVal;
  logic             t1En;
  logic             t1Mode;

  rt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMP_W(CMP_W), .RLD_W(RLD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hblankIn(hblankIn), .vblankOut(vblankOut),
    .dotTick(dotTick), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .strobe(strobe), .cmpVal(cmpVal), .rldVal(rldVal),
    .t1En(t1En), .t1Mode(t1Mode)
  );

  rt_datapath #(.CMP_W(CMP_W), .RLD_W(RLD_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpVal(cmpVal), .rldVal(rldVal),
    .t1En(t1En), .t1Mode(t1Mode), .timer0Pulse(timer0Pulse),
    .timer1Pulse(timer1Pulse)
  );

endmodule

// File: tb/sim_raster_dual_timer.sv
`timescale 1ns/1ps
module sim_raster_dual_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hblankIn = 1'b0, vblankOut = 1'b0, dotTick = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        timer0Pulse, timer1Pulse;

  int checks = 0;
  int errors = 0;
  int t0Count, t0At, t1Count, t1At, t1Line;
  int hbSeen = 0, lastHb = 0, tickCount = 0;
  logic [15:0] rdVal;

  always #5 clk = ~clk;

  raster_dual_timer u0 (
    .clk(clk), .rstN(rstN), .hblankIn(hblankIn), .vblankOut(vblankOut),
    .dotTick(dotTick), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .timer0Pulse(timer0Pulse), .timer1Pulse(timer1Pulse)
  );

  // Monitor: pulses first (result of the previous edge), then input bookkeeping
  always @(negedge clk) begin
    if (rstN) begin
      if (timer0Pulse) begin t0Count++; t0At = lastHb; end
      if (timer1Pulse) begin t1Count++; t1At = tickCount; t1Line = lastHb; end
      if (vblankOut) hbSeen = 0;
      if (hblankIn) begin lastHb = hbSeen; hbSeen++; tickCount = 0; end
      else if (dotTick) tickCount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic h, input logic v, input logic d);
    @(posedge clk); #2;
    hblankIn = h; vblankOut = v; dotTick = d;
  endtask

  task automatic settle();
    drive(0, 0, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic runLine(input int dots);
    drive(1, 0, 0);
    for (int i = 0; i < dots; i++) drive(0, 0, 1);
    drive(0, 0, 0);
  endtask

  task automatic frameStart();
    drive(0, 1, 0);
    drive(0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    regWr = 1'b1; regAddr = 2'(a); regWdata = 16'(d);
    @(posedge clk); #2;
    regWr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(posedge clk); #2;
    regAddr = 2'(a);
    @(negedge clk);
    v = regRdata;
  endtask

  task automatic clearCounts();
    settle();
    t0Count = 0; t0At = -1; t1Count = 0; t1At = -1; t1Line = -1;
  endtask

  task automatic testReset();
    for (int a = 0; a < 3; a++) begin
      rd(a, rdVal);
      check(rdVal == 0, "R1 register reset", int'(rdVal), 0);
    end
    check(timer0Pulse == 0 && timer1Pulse == 0, "R1 pulses idle", int'({timer0Pulse, timer1Pulse}), 0);
  endtask

  task automatic testRegs();
    wr(0, 16'hFFFF); wr(1, 16'hFFFF); wr(2, 16'hFFFF);
    rd(0, rdVal); check(rdVal == 16'h03FF, "R2 compare width", int'(rdVal), 16'h03FF);
    rd(1, rdVal); check(rdVal == 16'h01FF, "R2 reload width", int'(rdVal), 16'h01FF);
    rd(2, rdVal); check(rdVal == 16'h0081, "R2 control bits", int'(rdVal), 16'h0081);
    wr(2, 0);
    rd(2, rdVal); check(rdVal == 0, "R2 control clear", int'(rdVal), 0);
  endtask

  task automatic testTimer0();
    wr(0, 5); clearCounts();
    frameStart();
    for (int l = 0; l < 10; l++) runLine(3);
    settle();
    check(t0Count == 1, "R4 one match per frame", t0Count, 1);
    check(t0At == 5, "R3 match on line 5", t0At, 5);
    wr(0, 0); clearCounts();
    frameStart();
    for (int l = 0; l < 3; l++) runLine(1);
    settle();
    check(t0Count == 1 && t0At == 0, "R4 compare zero first blank", t0At, 0);
  endtask

  task automatic testNoFire();
    wr(0, 300); clearCounts();
    frameStart();
    for (int l = 0; l < 264; l++) runLine(0);
    settle();
    check(t0Count == 0, "R5 compare beyond frame", t0Count, 0);
    wr(0, 3); clearCounts();
    frameStart();
    for (int l = 0; l < 1030; l++) runLine(0);
    settle();
    check(t0Count == 1, "R5 no wrap match", t0Count, 1);
  endtask

  task automatic testTimer1();
    wr(0, 1023); wr(1, 4); wr(2, 16'h0001); clearCounts();
    frameStart();
    runLine(10);
    settle();
    check(t1Count == 1 && t1At == 4, "R6 fires at reload ticks", t1At, 4);
    runLine(10); runLine(2);
    settle();
    check(t1Count == 2, "R6 one pulse per full line", t1Count, 2);
    wr(1, 0); clearCounts();
    runLine(3); runLine(3);
    settle();
    check(t1Count == 2 && t1At == 0, "R7 reload zero at line start", t1At, 0);
    wr(1, 2); wr(2, 0); clearCounts();
    runLine(5); runLine(5);
    settle();
    check(t1Count == 0, "R8 disabled no pulse", t1Count, 0);
  endtask

  task automatic testLineMode();
    wr(0, 2); wr(1, 3); wr(2, 16'h0081); clearCounts();
    frameStart();
    for (int l = 0; l < 5; l++) runLine(6);
    settle();
    check(t1Count == 1, "R9 gated pulse count", t1Count, 1);
    check(t1Line == 2, "R9 gated line", t1Line, 2);
    wr(2, 0);
  endtask

  task automatic testCoincide();
    wr(0, 1023); wr(1, 2); wr(2, 16'h0001); clearCounts();
    drive(1, 0, 1);
    drive(0, 0, 1); drive(0, 0, 1); drive(0, 0, 1);
    settle();
    check(t1Count == 1 && t1At == 2, "R10 tick on blank ignored", t1At, 2);
    wr(0, 0); wr(2, 0); clearCounts();
    frameStart();
    runLine(1); runLine(1);
    settle();
    clearCounts();
    drive(1, 1, 0);
    drive(0, 0, 0);
    settle();
    check(t0Count == 1 && t0At == 0, "R10 clear before compare", t0Count, 1);
    runLine(1);
    settle();
    check(t0Count == 1, "R10 count left at one", t0Count, 1);
  endtask

  task automatic testMidWrite();
    wr(0, 1023); wr(1, 6); wr(2, 16'h0001); clearCounts();
    drive(1, 0, 0);
    drive(0, 0, 1);
    @(posedge clk); #2; dotTick = 1'b0;
    regWr = 1'b1; regAddr = 2'd1; regWdata = 16'd2;
    @(posedge clk); #2; regWr = 1'b0;
    for (int i = 0; i < 7; i++) drive(0, 0, 1);
    settle();
    check(t1Count == 1 && t1At == 6, "R11 running count kept", t1At, 6);
    clearCounts();
    runLine(5);
    settle();
    check(t1Count == 1 && t1At == 2, "R11 new reload next line", t1At, 2);
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    testReset();
    testRegs();
    testTimer0();
    testNoFire();
    testTimer1();
    testLineMode();
    testCoincide();
    testMidWrite();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule